// File: doc/BRIEF.md
# Multiplexed Address/Data Pseudo-SRAM Controller

This block sits between an on-chip host and an external pseudo-SRAM that shares one 16-bit bus between address and data. It runs single-word asynchronous reads and writes. Each transfer follows a fixed sequence. First the address phase drives the address with the address-valid strobe low. Address-valid then rises so the memory captures the address. The bus then changes direction or carries write data. Finally the cycle closes by raising the strobes. Every phase length is a cycle count set by a parameter, so one netlist can be tuned to the memory's access time and the host clock.

The host port uses a valid/ready handshake for requests. A request carries the direction, the address, the write data and a two-bit byte mask. The request is accepted on the edge where both `req_valid` and `req_ready` are high. `req_ready` is low during the power-up wait and for the whole of a transfer, which is how back-pressure reaches the host. The host may hold `req_valid` and its fields for as long as it likes. The response has no back-pressure: `rsp_valid` is a single-cycle pulse at the end of every transfer, and for a read it carries the word read. The host must take the response in that cycle.

After reset the controller keeps chip enable inactive and refuses requests until a power-up delay has been counted. The memory clock output is held low, and the memory's wait output is accepted but never used.

Top module: `admux_psram_ctrl`

## Requirements
- R1: After reset is released, `mem_ce_n` stays high and `req_ready` stays low for exactly `INIT_CYCLES` clock edges; `req_ready` is first seen high after edge number `INIT_CYCLES`. An asynchronous reset in the middle of a transfer returns all strobes high at once and restarts this wait.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` stays low from the accepting edge until after the response pulse, so a request held during a transfer starts nothing. A request held during the power-up wait starts nothing either.
- R3: The address phase lasts `ADDR_SETUP` cycles, starting in the first cycle after acceptance. In it `mem_ce_n` and `mem_adv_n` are low, `mem_oe_n` is high, `mem_be_n` equals the inverted request mask (bit 0 is the low byte), `mem_ad` carries the address, and `mem_we_n` is low for a write and high for a read.
- R4: For a read, after address-valid rises, one turnaround cycle follows with the bus released and output enable still high. `mem_oe_n` then goes low. The bus is sampled at the edge that ends cycle `ACC_CYC` counted from acceptance, so `mem_oe_n` is low for `ACC_CYC-ADDR_SETUP-1` cycles. `mem_oe_n` is never low while `mem_adv_n` is low.
- R5: A read ends with one cycle in which `mem_ce_n` and `mem_oe_n` are high and `rsp_valid` is high with `rsp_rdata` holding the sampled word. This is cycle `ACC_CYC+1` after acceptance, and `rsp_valid` is low in the following cycle.
- R6: For a write, data is driven onto `mem_ad` only after `mem_adv_n` has risen, and it is held with `mem_we_n` low for `WR_PULSE` cycles. Then `mem_we_n`, `mem_ce_n` and `mem_be_n` rise together while the data stays on the bus for that one further cycle.
- R7: `mem_we_n` is never low for more than `WE_MAX` consecutive cycles.
- R8: `mem_oe_n` is high in every cycle in which the controller drives `mem_ad`. After a read, the bus is driven again only after `mem_oe_n` has been high for at least one cycle.
- R9: `mem_clk` is constantly low. Toggling `mem_wait` has no effect on strobes, timing or read data.
- R10: A write ends with `rsp_valid` high for exactly one cycle, the cycle `ADDR_SETUP+WR_PULSE+1` after acceptance. That is the cycle in which the strobes rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Word address placed on the shared bus |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte, 1 = selected |
| rsp_valid | output | 1 | One-cycle end-of-transfer pulse |
| rsp_rdata | output | DW | Read word, valid with `rsp_valid` after a read |
| mem_clk | output | 1 | Memory clock, held low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low; its rise latches the address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 low byte |
| mem_wait | input | 1 | Memory wait indication, ignored |
| mem_ad | inout | DW | Shared address/data bus |

## Verification
Most wrong internal states show up as a wrong phase length, and the monitor catches this within the same transfer. A stuck or mis-loaded phase counter changes the number of cycles with address-valid, output-enable or write-enable low. It also moves the response pulse away from cycle `ACC_CYC+1` or `ADDR_SETUP+WR_PULSE+1`. A direction-control fault shows up in one of two ways. If the data drive starts too early, the bus holds the data while address-valid is still low, and the monitor sees it in that cycle. If the drive overlaps the memory's output, the read word is corrupted, and this shows in the response of that read. A wrong byte-mask latch or capture strobe appears one transfer later, when the following read returns a word that differs from the bench's shadow copy.

// File: rtl/admux_pkg.sv
package admux_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_RTURN = 3'd2,
    PH_RWAIT = 3'd3,
    PH_REND  = 3'd4,
    PH_WDATA = 3'd5,
    PH_WEND  = 3'd6
  } phase_e;

  function automatic logic phase_selects_chip(input phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_RTURN) ||
           (ph == PH_RWAIT) || (ph == PH_WDATA);
  endfunction

endpackage

// File: rtl/admux_init_timer.sv
module admux_init_timer #(
  parameter int INIT_CYCLES = 18750
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [IW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == IW'(INIT_CYCLES - 1)) done_q <= 1'b1;
      else                               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign init_done = done_q;

  // once finished, the flag only clears through reset
  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) |-> done_q);

endmodule

// File: rtl/admux_seq.sv
module admux_seq
  import admux_pkg::*;
#(
  parameter int DW         = 16,
  parameter int ADDR_SETUP = 2,
  parameter int ACC_CYC    = 9,
  parameter int WR_PULSE   = 6,
  parameter int WE_MAX     = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_done,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic [DW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          ce_n,
  output logic          adv_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [1:0]    be_n,
  output logic          drv_addr,
  output logic          drv_data,
  output logic          cap_en,
  output logic          rsp_valid
);
  localparam int RWAIT_CYC = ACC_CYC - ADDR_SETUP - 1;
  localparam int MAXC      = (ACC_CYC > WR_PULSE) ? ACC_CYC : WR_PULSE;
  localparam int CW        = $clog2(MAXC + 1);
  localparam int WW        = $clog2(WE_MAX + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [1:0]    be_q;
  logic          accept;

  assign req_ready = init_done && (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      wr_q      <= 1'b0;
      be_q      <= 2'b00;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            ph_q      <= PH_ADDR;
            cnt_q     <= CW'(ADDR_SETUP - 1);
            wr_q      <= req_write;
            be_q      <= req_be;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
          end
        end
        PH_ADDR: begin
          if (cnt_q == '0) begin
            if (wr_q) begin
              ph_q  <= PH_WDATA;
              cnt_q <= CW'(WR_PULSE - 1);
            end else begin
              ph_q  <= PH_RTURN;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RTURN: begin
          ph_q  <= PH_RWAIT;
          cnt_q <= CW'(RWAIT_CYC - 1);
        end
        PH_RWAIT: begin
          if (cnt_q == '0) ph_q  <= PH_REND;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_WDATA: begin
          if (cnt_q == '0) ph_q  <= PH_WEND;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_REND, PH_WEND: ph_q <= PH_IDLE;
        default:          ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ce_n      = !phase_selects_chip(ph_q);
    adv_n     = (ph_q != PH_ADDR);
    oe_n      = (ph_q != PH_RWAIT);
    we_n      = !(wr_q && ((ph_q == PH_ADDR) || (ph_q == PH_WDATA)));
    be_n      = phase_selects_chip(ph_q) ? ~be_q : 2'b11;
    drv_addr  = (ph_q == PH_ADDR);
    drv_data  = (ph_q == PH_WDATA) || (ph_q == PH_WEND);
    cap_en    = (ph_q == PH_RWAIT) && (cnt_q == '0);
    rsp_valid = (ph_q == PH_REND) || (ph_q == PH_WEND);
  end

  // write-enable low-time monitor
  logic [WW-1:0] we_lo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    we_lo_q <= '0;
    else if (!we_n) begin
      if (we_lo_q != WW'(WE_MAX))  we_lo_q <= we_lo_q + 1'b1;
    end else                       we_lo_q <= '0;
  end

  assert_we_low_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (we_lo_q < WW'(WE_MAX)));

  assert_no_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_oe_after_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> oe_n);

  assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_strobes_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && adv_n) |=> (!we_n || (ce_n && (be_n == 2'b11))));

  assert_quiet_until_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (ce_n && !req_ready));

endmodule

// File: rtl/admux_bus_io.sv
module admux_bus_io #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_addr,
  input  logic          drv_data,
  input  logic          cap_en,
  input  logic          oe_n,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rdata
);
  logic oe_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      oe_n_q <= 1'b1;
    end else begin
      oe_n_q <= oe_n;
      if (cap_en) rdata <= ad_in;
    end
  end

  assign ad_oe  = drv_addr || drv_data;
  assign ad_out = drv_data ? wdata : addr;

  // drive never overlaps, nor directly follows, a memory output cycle
  assert_drive_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (oe_n && oe_n_q));

endmodule

// File: rtl/admux_psram_ctrl.sv
module admux_psram_ctrl #(
  parameter int DW          = 16,
  parameter int INIT_CYCLES = 18750,
  parameter int ADDR_SETUP  = 2,
  parameter int ACC_CYC     = 9,
  parameter int WR_PULSE    = 6,
  parameter int WE_MAX      = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_clk,
  output logic          mem_ce_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [1:0]    mem_be_n,
  input  logic          mem_wait,
  inout  wire  [DW-1:0] mem_ad
);
  logic          init_done;
  logic [DW-1:0] lat_addr, lat_wdata;
  logic          drv_addr, drv_data, cap_en;
  logic [DW-1:0] ad_out;
  logic          ad_oe;
  logic          unused_wait;

  assign unused_wait = mem_wait;
  assign mem_clk     = 1'b0;

  admux_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done)
  );

  admux_seq #(
    .DW         (DW),
    .ADDR_SETUP (ADDR_SETUP),
    .ACC_CYC    (ACC_CYC),
    .WR_PULSE   (WR_PULSE),
    .WE_MAX     (WE_MAX)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .ce_n      (mem_ce_n),
    .adv_n     (mem_adv_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .be_n      (mem_be_n),
    .drv_addr  (drv_addr),
    .drv_data  (drv_data),
    .cap_en    (cap_en),
    .rsp_valid (rsp_valid)
  );

  admux_bus_io #(.DW(DW)) u_io (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_addr (drv_addr),
    .drv_data (drv_data),
    .cap_en   (cap_en),
    .oe_n     (mem_oe_n),
    .addr     (lat_addr),
    .wdata    (lat_wdata),
    .ad_in    (mem_ad),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .rdata    (rsp_rdata)
  );

  assign mem_ad = ad_oe ? ad_out : {DW{1'bz}};

  assert_data_after_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && mem_adv_n) |-> !mem_we_n || mem_ce_n);

  assert_clock_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mem_clk));

  assert_ce_with_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_ce_n && ad_oe));

endmodule

// File: tb/admux_psram_ctrl_bench.sv
module admux_psram_ctrl_bench;
  localparam int INIT = 100;
  localparam int S    = 2;
  localparam int ACC  = 6;
  localparam int P    = 3;
  localparam int WMAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_be = 2'b00;
  logic mem_wait = 1'b0;
  logic req_ready, rsp_valid, mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n;
  logic [1:0] mem_be_n;
  logic [15:0] rsp_rdata;
  wire  [15:0] mem_ad;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  admux_psram_ctrl #(
    .DW(16), .INIT_CYCLES(INIT), .ADDR_SETUP(S), .ACC_CYC(ACC),
    .WR_PULSE(P), .WE_MAX(WMAX)
  ) u_admux_psram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_wait(mem_wait), .mem_ad(mem_ad)
  );

  function automatic logic [15:0] init_word(input logic [3:0] i);
    return {4{i}} ^ 16'hA5A5;
  endfunction

  // memory model and independent shadow copy
  logic [15:0] mem [16];
  logic [15:0] shadow [16];
  logic [3:0]  lat_a = '0;
  logic        prev_we = 1'b1, prev_ce = 1'b1;
  logic [1:0]  prev_be = 2'b11;

  initial for (int i = 0; i < 16; i++) begin
    mem[i] = init_word(4'(i));
    shadow[i] = init_word(4'(i));
  end

  assign mem_ad = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[lat_a] : 16'hzzzz;

  always @(negedge clk) begin
    if (!mem_adv_n && !mem_ce_n) lat_a <= mem_ad[3:0];
    if (!prev_we && !prev_ce && mem_we_n) begin
      if (!prev_be[0]) mem[lat_a][7:0]  <= mem_ad[7:0];
      if (!prev_be[1]) mem[lat_a][15:8] <= mem_ad[15:8];
    end
    prev_we <= mem_we_n;
    prev_ce <= mem_ce_n;
    prev_be <= mem_be_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_xfer(input logic wr, input logic [1:0] be, input logic [15:0] a, input logic [15:0] d);
    int cyc = 1, adv_lo = 0, we_lo = 0, oe_lo = 0;
    bit addr_ok = 1, data_ok = 1, ord_ok = 1, rdy_ok = 1, clk_ok = 1, hold_ok = 1;
    logic [15:0] exp_rd, got;
    exp_rd = shadow[a[3:0]];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (cyc < 64) begin
      mem_wait = ~mem_wait;
      if (!mem_adv_n) begin
        adv_lo++;
        if (mem_ad !== a || !mem_oe_n || mem_ce_n || mem_be_n != ~be || mem_we_n == wr) addr_ok = 0;
      end
      if (!mem_we_n) begin
        we_lo++;
        if (mem_adv_n && mem_ad !== d) data_ok = 0;
      end
      if (!mem_oe_n) begin
        oe_lo++;
        if (!mem_adv_n) ord_ok = 0;
      end
      if (req_ready) rdy_ok = 0;
      if (mem_clk !== 1'b0) clk_ok = 0;
      if (rsp_valid) break;
      cyc++;
      @(negedge clk);
    end
    got = rsp_rdata;
    if (wr && (mem_ad !== d || !mem_we_n == 1'b1 || !mem_ce_n || mem_be_n != 2'b11)) hold_ok = 0;
    chk(adv_lo == S && addr_ok, "R3 address phase", 32'(adv_lo), 32'(S));
    chk(rdy_ok, "R2 ready low while busy", 32'(rdy_ok), 1);
    chk(clk_ok, "R9 memory clock static", 32'(clk_ok), 1);
    if (wr) begin
      chk(cyc == S + P + 1, "R10 write response cycle", 32'(cyc), 32'(S + P + 1));
      chk(we_lo == S + P && data_ok, "R6 write data phase", 32'(we_lo), 32'(S + P));
      chk(hold_ok, "R6 data held as strobes rise", 32'(mem_ad), 32'(d));
      chk(we_lo <= WMAX, "R7 write enable bound", 32'(we_lo), 32'(WMAX));
      if (be[0]) shadow[a[3:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[3:0]][15:8] = d[15:8];
    end else begin
      chk(cyc == ACC + 1, "R5 read response cycle", 32'(cyc), 32'(ACC + 1));
      chk(oe_lo == ACC - S - 1 && ord_ok, "R4 output enable window", 32'(oe_lo), 32'(ACC - S - 1));
      chk(got === exp_rd, "R5 read data", 32'(got), 32'(exp_rd));
      chk(mem_oe_n && mem_ce_n, "R8 strobes high at read end", {mem_oe_n, mem_ce_n}, 2'b11);
    end
    @(negedge clk);
    chk(!rsp_valid, "R5 R10 response is one pulse", 32'(rsp_valid), 0);
  endtask

  // {write, byte mask, address, data}
  localparam logic [34:0] VEC [11] = '{
    {1'b1, 2'b11, 16'h0003, 16'h1234},
    {1'b0, 2'b11, 16'h0003, 16'h0000},
    {1'b1, 2'b01, 16'h0003, 16'hABCD},
    {1'b0, 2'b11, 16'h0003, 16'h0000},
    {1'b1, 2'b10, 16'h0007, 16'h5A77},
    {1'b0, 2'b01, 16'h0007, 16'h0000},
    {1'b0, 2'b11, 16'h000C, 16'h0000},
    {1'b1, 2'b00, 16'h000C, 16'hFFFF},
    {1'b0, 2'b11, 16'h000C, 16'h0000},
    {1'b1, 2'b11, 16'hFFF0, 16'h0F0F},
    {1'b0, 2'b10, 16'h0000, 16'h0000}
  };

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic wait_init(input string tag);
    int k = 0;
    bit ce_ok = 1;
    while (!req_ready && k < INIT + 10) begin
      @(negedge clk);
      k++;
      if (!mem_ce_n) ce_ok = 0;
    end
    req_valid = 0;
    chk(k == INIT && ce_ok, tag, 32'(k), 32'(INIT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !req_ready && !rsp_valid,
        "R1 reset state", {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_be_n, req_ready, rsp_valid},
        8'b1111_1100);
    // request held during power-up wait must start nothing
    req_valid = 1; req_write = 1; req_be = 2'b11; req_addr = 16'h0005; req_wdata = 16'hDEAD;
    rst_n = 1;
    wait_init("R1 R2 power-up wait");
    @(negedge clk);
    chk(mem_ce_n && mem_we_n, "R2 held request not started", {mem_ce_n, mem_we_n}, 2'b11);

    for (int v = 0; v < 11; v++)
      do_xfer(VEC[v][34], VEC[v][33:32], VEC[v][31:16], VEC[v][15:0]);

    // address 5 must be untouched by the request seen during power-up
    do_xfer(1'b0, 2'b11, 16'h0005, 16'h0000);

    // reset in the middle of a write (address 0xF is not read afterwards)
    @(negedge clk);
    req_valid = 1; req_write = 1; req_be = 2'b11; req_addr = 16'h000F; req_wdata = 16'h1111;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(mem_ce_n && mem_we_n && mem_adv_n && mem_be_n == 2'b11, "R1 async reset mid transfer",
        {mem_ce_n, mem_we_n, mem_adv_n, mem_be_n}, 5'b11111);
    @(negedge clk);
    rst_n = 1;
    wait_init("R1 power-up wait after reset");

    do_xfer(1'b1, 2'b11, 16'h0009, 16'hC3C3);
    do_xfer(1'b0, 2'b11, 16'h0009, 16'h0000);
    finish_run();
  end

endmodule